// File: doc/BRIEF.md
# Depth-Test and Buffer-Copy Unit

This block performs hidden-surface removal for a stream of fragments. It also moves colour data between the colour store and the depth store. Each fragment carries a pixel position, a 24-bit depth and a colour. The unit reads the depth already held for that pixel and compares the two values. When the fragment is closer, it writes the fragment's colour and depth back. Fragment handling runs as a three-step pipeline: read, compare, write. Back-to-back fragments that hit the same pixel see each other's results through forwarding.

A 2-bit mode selects the operation. Two modes handle fragments: depth-tested writes, and unconditional writes with the test bypassed. The other two modes use the depth memory as off-screen storage for a rectangle of the colour store. Save copies colour into depth memory, and restore copies it back. The data never leaves the block. A separate clear command fills a rectangle of the depth store with the farthest value. Rectangle operations run at one pixel per clock and end with a single-cycle `done` pulse.

A registered scan port reads colour and depth at any pixel. This is how downstream display logic sees the stores.

Top module: `zbuf_copy_unit`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: With `mode` = 0 (depth test), a fragment passes only when its depth is strictly less than the stored depth. On a pass, the colour and the depth at {y,x} both take the fragment's values. An equal depth fails.
- R3: A fragment that fails the depth test leaves both the colour and the depth of its pixel unchanged.
- R4: With `mode` = 1 (always write), every fragment writes its colour and depth, whatever depth is stored.
- R5: A clear command (`rect_start` with `rect_clear` = 1) writes 24'hFFFFFF into the depth store for every pixel with x0 ≤ x ≤ x1 and y0 ≤ y ≤ y1, bounds inclusive. Pixels outside the rectangle keep their values.
- R6: `rect_start` with `mode` = 2 (save) copies the colour of every pixel of the rectangle into the depth store at the same pixel.
- R7: `rect_start` with `mode` = 3 (restore) copies the depth-store word of every pixel of the rectangle into the colour store at the same pixel.
- R8: A fragment issued one or two cycles after an earlier fragment to the same pixel is compared against the earlier fragment's written depth, not against the stale memory word.
- R9: A rectangle of N pixels is processed at one pixel per cycle. `done` goes high in the cycle after posedge N+3, counting the posedge that samples `rect_start` as posedge 1. `done` stays high for exactly one cycle, and `busy` falls at the same edge.
- R10: While `busy` is 1, fragments and further `rect_start` requests are ignored.
- R11: With `mode` = 2 or 3, fragments are ignored.
- R12: `scan_color` and `scan_depth` show the stored values at {`scan_y`,`scan_x`} one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 test, 1 always write, 2 save, 3 restore |
| frag_valid | input | 1 | Fragment present this cycle |
| frag_x | input | XW | Fragment column |
| frag_y | input | YW | Fragment row |
| frag_z | input | DW | Fragment depth |
| frag_color | input | CW | Fragment colour |
| rect_start | input | 1 | Start a rectangle operation |
| rect_clear | input | 1 | Rectangle operation is a depth clear |
| rect_x0 | input | XW | First column |
| rect_y0 | input | YW | First row |
| rect_x1 | input | XW | Last column |
| rect_y1 | input | YW | Last row |
| busy | output | 1 | Rectangle operation in progress |
| done | output | 1 | One-cycle pulse after the last rectangle write |
| scan_x | input | XW | Scan read column |
| scan_y | input | YW | Scan read row |
| scan_color | output | CW | Stored colour at scan address |
| scan_depth | output | DW | Stored depth at scan address |

## Verification
The hardest case to reach from the ports is forwarding. A fragment has to compare against a depth that is still in flight, either waiting in the write stage or being committed in the same edge the new read happens. The bench drives fragments to one pixel on consecutive cycles and with a single idle cycle between them. The depths are chosen so that a stale read would flip the pass/fail outcome. The bench also drives fragments and a second command while a clear is running, then checks an untouched pixel outside the rectangle.

// File: rtl/zc_pkg.sv
package zc_pkg;
  typedef enum logic [1:0] {
    MODE_TEST    = 2'd0,
    MODE_ALWAYS  = 2'd1,
    MODE_SAVE    = 2'd2,
    MODE_RESTORE = 2'd3
  } zc_mode_e;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_TEST    = 3'd1,
    OP_ALWAYS  = 3'd2,
    OP_CLEAR   = 3'd3,
    OP_SAVE    = 3'd4,
    OP_RESTORE = 3'd5
  } zc_op_e;
endpackage

// File: rtl/zc_ram.sv
module zc_ram #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          ra_en,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ra_q;
  logic [DW-1:0] rb_q;

  // read-first: a read and a write at the same edge return the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (ra_en) ra_q <= mem[ra_addr];
    rb_q <= mem[rb_addr];
  end

  assign ra_data = ra_q;
  assign rb_data = rb_q;
endmodule

// File: rtl/zc_rect_walker.sv
module zc_rect_walker #(
  parameter int XW = 4,
  parameter int YW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [XW-1:0] x0,
  input  logic [YW-1:0] y0,
  input  logic [XW-1:0] x1,
  input  logic [YW-1:0] y1,
  output logic          valid,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          last
);
  logic          act_q, act_d;
  logic [XW-1:0] x_q, x_d, xs_q, xe_q;
  logic [YW-1:0] y_q, y_d, ye_q;
  logic          row_end, rect_end;

  assign row_end  = (x_q == xe_q);
  assign rect_end = row_end && (y_q == ye_q);

  always_comb begin
    act_d = act_q;
    x_d   = x_q;
    y_d   = y_q;
    if (start) begin
      act_d = 1'b1;
      x_d   = x0;
      y_d   = y0;
    end else if (act_q) begin
      if (row_end) begin
        x_d = xs_q;
        if (rect_end) act_d = 1'b0;
        else          y_d   = y_q + 1'b1;
      end else begin
        x_d = x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      x_q   <= '0;
      y_q   <= '0;
      xs_q  <= '0;
      xe_q  <= '0;
      ye_q  <= '0;
    end else begin
      act_q <= act_d;
      x_q   <= x_d;
      y_q   <= y_d;
      if (start) begin
        xs_q <= x0;
        xe_q <= x1;
        ye_q <= y1;
      end
    end
  end

  assign valid = act_q;
  assign x     = x_q;
  assign y     = y_q;
  assign last  = act_q && rect_end;

  // R9: the last pixel closes the walk; the next cycle issues nothing
  assert_last_ends_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && last) |=> !valid);
endmodule

// File: rtl/zc_depth_cmp.sv
module zc_depth_cmp #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] mem_z,
  input  logic [DW-1:0] frag_z,
  input  logic          fa_we,
  input  logic [AW-1:0] fa_addr,
  input  logic [DW-1:0] fa_z,
  input  logic          fb_we,
  input  logic [AW-1:0] fb_addr,
  input  logic [DW-1:0] fb_z,
  output logic [DW-1:0] eff_z,
  output logic          closer
);
  // fa is the younger pending write and takes priority over fb
  always_comb begin
    if (fa_we && (fa_addr == addr))      eff_z = fa_z;
    else if (fb_we && (fb_addr == addr)) eff_z = fb_z;
    else                                 eff_z = mem_z;
  end

  assign closer = (frag_z < eff_z);
endmodule

// File: rtl/zbuf_copy_unit.sv
module zbuf_copy_unit
  import zc_pkg::*;
#(
  parameter int XW = 4,
  parameter int YW = 4,
  parameter int DW = 24,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          frag_valid,
  input  logic [XW-1:0] frag_x,
  input  logic [YW-1:0] frag_y,
  input  logic [DW-1:0] frag_z,
  input  logic [CW-1:0] frag_color,
  input  logic          rect_start,
  input  logic          rect_clear,
  input  logic [XW-1:0] rect_x0,
  input  logic [YW-1:0] rect_y0,
  input  logic [XW-1:0] rect_x1,
  input  logic [YW-1:0] rect_y1,
  output logic          busy,
  output logic          done,
  input  logic [XW-1:0] scan_x,
  input  logic [YW-1:0] scan_y,
  output logic [CW-1:0] scan_color,
  output logic [DW-1:0] scan_depth
);
  localparam int AW = XW + YW;
  localparam logic [DW-1:0] ZFAR = {DW{1'b1}};

  zc_mode_e mode_e;
  assign mode_e = zc_mode_e'(mode);

  // ---------------- issue stage ----------------
  logic          busy_q, busy_d, done_q, done_d;
  zc_op_e        rect_op_q, rect_op_d;
  logic          rect_go, frag_go;
  logic          walk_valid, walk_last;
  logic [XW-1:0] walk_x;
  logic [YW-1:0] walk_y;
  logic          issue_valid;
  logic [AW-1:0] issue_addr;
  zc_op_e        issue_op;

  assign rect_go = rect_start && !busy_q &&
                   (rect_clear || mode_e == MODE_SAVE || mode_e == MODE_RESTORE);
  assign frag_go = frag_valid && !busy_q &&
                   (mode_e == MODE_TEST || mode_e == MODE_ALWAYS);

  zc_rect_walker #(.XW(XW), .YW(YW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(rect_go),
    .x0(rect_x0), .y0(rect_y0), .x1(rect_x1), .y1(rect_y1),
    .valid(walk_valid), .x(walk_x), .y(walk_y), .last(walk_last)
  );

  always_comb begin
    issue_valid = walk_valid || frag_go;
    issue_addr  = walk_valid ? {walk_y, walk_x} : {frag_y, frag_x};
    if (walk_valid)                 issue_op = rect_op_q;
    else if (!frag_go)              issue_op = OP_NONE;
    else if (mode_e == MODE_TEST)   issue_op = OP_TEST;
    else                            issue_op = OP_ALWAYS;
  end

  always_comb begin
    rect_op_d = rect_op_q;
    if (rect_go) begin
      if (rect_clear)               rect_op_d = OP_CLEAR;
      else if (mode_e == MODE_SAVE) rect_op_d = OP_SAVE;
      else                          rect_op_d = OP_RESTORE;
    end
  end

  // ---------------- stage 1 (read data back, compare) ----------------
  zc_op_e        s1_op;
  logic          s1_last;
  logic [AW-1:0] s1_addr;
  logic [DW-1:0] s1_z;
  logic [CW-1:0] s1_c;

  // stage 2 holds the write going to memory; stage 3 remembers the one just committed
  logic          s2_zwe, s2_cwe, s2_last, s2_test;
  logic [AW-1:0] s2_addr;
  logic [DW-1:0] s2_zval;
  logic [CW-1:0] s2_cval;
  logic          s3_zwe;
  logic [AW-1:0] s3_addr;
  logic [DW-1:0] s3_zval;

  logic [DW-1:0] z_rd, eff_z;
  logic [CW-1:0] c_rd;
  logic          closer;
  logic          w_zwe, w_cwe;
  logic [DW-1:0] w_zval;
  logic [CW-1:0] w_cval;

  zc_ram #(.AW(AW), .DW(DW)) u_zmem (
    .clk(clk), .we(s2_zwe), .waddr(s2_addr), .wdata(s2_zval),
    .ra_en(issue_valid), .ra_addr(issue_addr), .ra_data(z_rd),
    .rb_addr({scan_y, scan_x}), .rb_data(scan_depth)
  );

  zc_ram #(.AW(AW), .DW(CW)) u_cmem (
    .clk(clk), .we(s2_cwe), .waddr(s2_addr), .wdata(s2_cval),
    .ra_en(issue_valid), .ra_addr(issue_addr), .ra_data(c_rd),
    .rb_addr({scan_y, scan_x}), .rb_data(scan_color)
  );

  zc_depth_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .addr(s1_addr), .mem_z(z_rd), .frag_z(s1_z),
    .fa_we(s2_zwe), .fa_addr(s2_addr), .fa_z(s2_zval),
    .fb_we(s3_zwe), .fb_addr(s3_addr), .fb_z(s3_zval),
    .eff_z(eff_z), .closer(closer)
  );

  always_comb begin
    w_zwe  = 1'b0;
    w_cwe  = 1'b0;
    w_zval = s1_z;
    w_cval = s1_c;
    unique case (s1_op)
      OP_TEST: begin
        w_zwe = closer;
        w_cwe = closer;
      end
      OP_ALWAYS: begin
        w_zwe = 1'b1;
        w_cwe = 1'b1;
      end
      OP_CLEAR: begin
        w_zwe  = 1'b1;
        w_zval = ZFAR;
      end
      OP_SAVE: begin
        w_zwe  = 1'b1;
        w_zval = '0;
        w_zval[CW-1:0] = c_rd;
      end
      OP_RESTORE: begin
        w_cwe  = 1'b1;
        w_cval = z_rd[CW-1:0];
      end
      default: ;
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    if (rect_go)      busy_d = 1'b1;
    else if (s2_last) busy_d = 1'b0;
    done_d = s2_last;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      rect_op_q <= OP_NONE;
      s1_op     <= OP_NONE;
      s1_last   <= 1'b0;
      s2_zwe    <= 1'b0;
      s2_cwe    <= 1'b0;
      s2_last   <= 1'b0;
      s2_test   <= 1'b0;
      s3_zwe    <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      done_q    <= done_d;
      rect_op_q <= rect_op_d;
      s1_op     <= issue_valid ? issue_op : OP_NONE;
      s1_last   <= walk_valid && walk_last;
      s2_zwe    <= w_zwe;
      s2_cwe    <= w_cwe;
      s2_last   <= s1_last;
      s2_test   <= (s1_op == OP_TEST);
      s3_zwe    <= s2_zwe;
    end
  end

  // datapath registers, loaded only under their enables
  always_ff @(posedge clk) begin
    if (issue_valid) begin
      s1_addr <= issue_addr;
      s1_z    <= frag_z;
      s1_c    <= frag_color;
    end
    if (s1_op != OP_NONE) begin
      s2_addr <= s1_addr;
      s2_zval <= w_zval;
      s2_cval <= w_cval;
    end
    if (s2_zwe) begin
      s3_addr <= s2_addr;
      s3_zval <= s2_zval;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R9: done is a single-cycle pulse
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: busy only ends together with done
  assert_busy_ends_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R10: no fragment enters the pipeline while a rectangle operation holds busy
  assert_no_frag_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !(s1_op == OP_TEST || s1_op == OP_ALWAYS));
  // R2: a tested fragment never updates colour without depth
  assert_test_writes_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_test && s2_cwe) |-> s2_zwe);
endmodule

// File: tb/zbuf_copy_unit_test.sv
module zbuf_copy_unit_test;
  localparam int XW = 4, YW = 4, DW = 24, CW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic          frag_valid;
  logic [XW-1:0] frag_x;
  logic [YW-1:0] frag_y;
  logic [DW-1:0] frag_z;
  logic [CW-1:0] frag_color;
  logic          rect_start, rect_clear;
  logic [XW-1:0] rect_x0, rect_x1;
  logic [YW-1:0] rect_y0, rect_y1;
  logic          busy, done;
  logic [XW-1:0] scan_x;
  logic [YW-1:0] scan_y;
  logic [CW-1:0] scan_color;
  logic [DW-1:0] scan_depth;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  zbuf_copy_unit #(.XW(XW), .YW(YW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .frag_valid(frag_valid), .frag_x(frag_x), .frag_y(frag_y),
    .frag_z(frag_z), .frag_color(frag_color),
    .rect_start(rect_start), .rect_clear(rect_clear),
    .rect_x0(rect_x0), .rect_y0(rect_y0), .rect_x1(rect_x1), .rect_y1(rect_y1),
    .busy(busy), .done(done),
    .scan_x(scan_x), .scan_y(scan_y), .scan_color(scan_color), .scan_depth(scan_depth)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive_frag(input int x, input int y, input int z, input int c);
    @(negedge clk);
    frag_valid = 1'b1;
    frag_x = XW'(x); frag_y = YW'(y); frag_z = DW'(z); frag_color = CW'(c);
  endtask

  task automatic end_frag;
    @(negedge clk);
    frag_valid = 1'b0;
  endtask

  task automatic one_frag(input int x, input int y, input int z, input int c);
    drive_frag(x, y, z, c);
    end_frag();
    idle(3);
  endtask

  task automatic peek(input int x, input int y, output logic [CW-1:0] c, output logic [DW-1:0] z);
    @(negedge clk);
    scan_x = XW'(x); scan_y = YW'(y);
    @(negedge clk);
    c = scan_color; z = scan_depth;
  endtask

  // returns number of posedges from the sampling edge until done is seen
  task automatic run_rect(input logic clr, input int x0, input int y0, input int x1, input int y1,
                          output int k);
    @(negedge clk);
    rect_start = 1'b1; rect_clear = clr;
    rect_x0 = XW'(x0); rect_y0 = YW'(y0); rect_x1 = XW'(x1); rect_y1 = YW'(y1);
    @(negedge clk);
    rect_start = 1'b0; rect_clear = 1'b0;
    k = 1;
    while (!done && k < 2000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle(3);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 done after reset", 64'(done), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic t_clear_full;
    int k;
    logic [CW-1:0] c; logic [DW-1:0] z;
    mode = 2'd0;
    run_rect(1'b1, 0, 0, 15, 15, k);
    chk("R9 done latency 256 px", 64'(k), 64'd259);
    chk("R9 busy low at done", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R9 done one cycle", 64'(done), 64'd0);
    peek(0, 0, c, z);   chk("R5 clear corner lo", 64'(z), 64'hFFFFFF);
    peek(15, 15, c, z); chk("R5 clear corner hi", 64'(z), 64'hFFFFFF);
    peek(7, 9, c, z);   chk("R5 clear middle", 64'(z), 64'hFFFFFF);
  endtask

  task automatic t_always;
    logic [CW-1:0] c; logic [DW-1:0] z;
    mode = 2'd1;
    one_frag(2, 3, 1000, 24'hABCDEF);
    peek(2, 3, c, z);
    chk("R4 always colour", 64'(c), 64'hABCDEF);
    chk("R4 always depth", 64'(z), 64'd1000);
    one_frag(2, 3, 5000, 24'h111111);
    peek(2, 3, c, z);
    chk("R4 farther still written colour", 64'(c), 64'h111111);
    chk("R4 farther still written depth", 64'(z), 64'd5000);
  endtask

  task automatic t_test;
    logic [CW-1:0] c; logic [DW-1:0] z;
    mode = 2'd0;
    one_frag(2, 3, 4000, 24'h222222);
    peek(2, 3, c, z);
    chk("R2 pass colour", 64'(c), 64'h222222);
    chk("R2 pass depth", 64'(z), 64'd4000);
    one_frag(2, 3, 4500, 24'h333333);
    peek(2, 3, c, z);
    chk("R3 fail keeps colour", 64'(c), 64'h222222);
    chk("R3 fail keeps depth", 64'(z), 64'd4000);
    one_frag(2, 3, 4000, 24'h444444);
    peek(2, 3, c, z);
    chk("R2 equal depth fails", 64'(c), 64'h222222);
  endtask

  task automatic t_forward;
    logic [CW-1:0] c; logic [DW-1:0] z;
    mode = 2'd0;
    // consecutive, second farther: must see the first's depth
    drive_frag(5, 5, 100, 24'h0000A1);
    drive_frag(5, 5, 200, 24'h0000B2);
    end_frag(); idle(3);
    peek(5, 5, c, z);
    chk("R8 back-to-back colour", 64'(c), 64'h0000A1);
    chk("R8 back-to-back depth", 64'(z), 64'd100);
    // one idle cycle between, second farther
    drive_frag(6, 5, 300, 24'h0000C3);
    end_frag();
    drive_frag(6, 5, 400, 24'h0000D4);
    end_frag(); idle(3);
    peek(6, 5, c, z);
    chk("R8 gap-of-one colour", 64'(c), 64'h0000C3);
    chk("R8 gap-of-one depth", 64'(z), 64'd300);
    // consecutive, second closer
    drive_frag(7, 5, 300, 24'h0000E5);
    drive_frag(7, 5, 250, 24'h0000F6);
    end_frag(); idle(3);
    peek(7, 5, c, z);
    chk("R8 closer second colour", 64'(c), 64'h0000F6);
    chk("R8 closer second depth", 64'(z), 64'd250);
  endtask

  task automatic t_save_restore;
    int k;
    logic [CW-1:0] c; logic [DW-1:0] z;
    mode = 2'd1;
    for (int y = 1; y <= 2; y++)
      for (int x = 8; x <= 10; x++)
        one_frag(x, y, 24'h700000 + x, 24'h500000 + x * 16 + y);
    mode = 2'd2;
    run_rect(1'b0, 8, 1, 10, 2, k);
    chk("R9 done latency 6 px", 64'(k), 64'd9);
    peek(9, 2, c, z); chk("R6 saved depth 9,2", 64'(z), 64'h500092);
    peek(10, 1, c, z); chk("R6 saved depth 10,1", 64'(z), 64'h5000A1);
    mode = 2'd1;
    one_frag(9, 2, 24'h123456, 24'h000000);
    mode = 2'd3;
    run_rect(1'b0, 8, 1, 10, 2, k);
    peek(9, 2, c, z); chk("R7 restored from depth word", 64'(c), 64'h123456);
    peek(8, 1, c, z); chk("R7 round trip colour", 64'(c), 64'h500081);
  endtask

  task automatic t_busy;
    int k;
    logic [CW-1:0] c; logic [DW-1:0] z;
    mode = 2'd1;
    one_frag(15, 15, 77, 24'h777777);
    @(negedge clk);
    rect_start = 1'b1; rect_clear = 1'b1;
    rect_x0 = '0; rect_y0 = '0; rect_x1 = XW'(3); rect_y1 = YW'(3);
    @(negedge clk);
    rect_start = 1'b0; rect_clear = 1'b0;
    @(negedge clk);
    frag_valid = 1'b1; frag_x = '1; frag_y = '1; frag_z = DW'(1); frag_color = 24'h999999;
    rect_start = 1'b1; rect_clear = 1'b1;
    rect_x0 = '1; rect_y0 = '1; rect_x1 = '1; rect_y1 = '1;
    @(negedge clk);
    frag_valid = 1'b0; rect_start = 1'b0; rect_clear = 1'b0;
    k = 0;
    while (!done && k < 2000) begin @(negedge clk); k++; end
    idle(4);
    chk("R10 second start ignored, busy stays low", 64'(busy), 64'd0);
    peek(15, 15, c, z);
    chk("R10 frag during busy colour", 64'(c), 64'h777777);
    chk("R5 outside rect depth kept", 64'(z), 64'd77);
    peek(2, 3, c, z);
    chk("R5 inside rect cleared", 64'(z), 64'hFFFFFF);
    chk("R5 clear keeps colour", 64'(c), 64'h222222);
  endtask

  task automatic t_mode_ignore;
    logic [CW-1:0] c; logic [DW-1:0] z;
    mode = 2'd2;
    one_frag(7, 5, 1, 24'h000055);
    mode = 2'd3;
    one_frag(7, 5, 2, 24'h000066);
    peek(7, 5, c, z);
    chk("R11 frag ignored in copy modes colour", 64'(c), 64'h0000F6);
    chk("R11 frag ignored in copy modes depth", 64'(z), 64'd250);
  endtask

  task automatic t_scan;
    logic [CW-1:0] c; logic [DW-1:0] z;
    peek(5, 5, c, z);
    @(negedge clk);
    scan_x = XW'(6); scan_y = YW'(5);
    #1;
    chk("R12 output holds before edge", 64'(scan_color), 64'h0000A1);
    @(negedge clk);
    chk("R12 output after one edge", 64'(scan_color), 64'h0000C3);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    mode = 2'd0; frag_valid = 1'b0; frag_x = '0; frag_y = '0; frag_z = '0; frag_color = '0;
    rect_start = 1'b0; rect_clear = 1'b0;
    rect_x0 = '0; rect_y0 = '0; rect_x1 = '0; rect_y1 = '0;
    scan_x = '0; scan_y = '0;
    t_reset();
    t_clear_full();
    t_always();
    t_test();
    t_forward();
    t_save_restore();
    t_busy();
    t_mode_ignore();
    t_scan();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule